// File: doc/BRIEF.md
# Interrupt Acknowledge Vector Sequencer

This block produces the byte that an interrupt controller returns to the CPU on each interrupt acknowledge pulse. It counts the pulses of one acknowledge sequence and supports two CPU response modes. In the three-pulse call mode, the first pulse returns a CALL opcode. The second returns the low byte of the service-routine address, with the interrupt level inserted into it. The third returns the programmed high address byte. In the two-pulse pointer mode, the first pulse leaves the bus undriven and the second returns an 8-bit pointer built from five programmed base bits and the level.

Each acknowledge pulse arrives as a one-cycle strobe synchronous to `clk`. The byte, its drive enable and two strobes for the request core are registered and hold for exactly the one cycle after the strobe. `set_isr` tells the request core which pulse moves the request into service, and `last_pulse` marks the pulse that ends the sequence. The CPU paces the sequence, so the outputs have no ready input and no back-pressure. A strobe is never held off, and the consumer must take each byte in the cycle it is valid. Priority resolution, command decoding and cascade handling sit outside this block.

Top module: `iack_vector_seq`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `data_out`, `data_oe`, `set_isr` and `last_pulse` are all 0. The pulse counter starts at the first pulse.
- R2: In call mode (`mode_8bit`=1), the first strobe yields `data_out`=0xCD with `data_oe`=1 and `set_isr`=1. `last_pulse` stays 0 on this pulse.
- R3: In call mode with `intv4`=1, the second strobe yields `{vec_lo_bits[2:0], level[2:0], 2'b00}`, with `data_oe`=1 and both strobes at 0.
- R4: In call mode with `intv4`=0, the second strobe yields `{vec_lo_bits[2:1], level[2:0], 3'b000}`, and `vec_lo_bits[0]` has no effect on the byte.
- R5: In call mode, the third strobe yields `vec_hi_byte` with `data_oe`=1 and `last_pulse`=1. The next strobe is treated as a first pulse again.
- R6: The level used in the vector is the value of `level` sampled on the pulse that raises `set_isr`. In call mode, changes to `level` after the first pulse do not alter the low address byte.
- R7: In pointer mode (`mode_8bit`=0), the first strobe leaves `data_oe`=0 and `data_out`=0 and raises neither strobe.
- R8: In pointer mode, the second strobe yields `{ptr_base[4:0], level[2:0]}` with `data_oe`=1, and `set_isr` and `last_pulse` both high in the same cycle. The next strobe is treated as a first pulse again.
- R9: `init_start` returns the counter to the first pulse. A strobe in the same cycle as `init_start` is ignored: no output is driven and no strobe is raised.
- R10: Each output is valid only in the cycle right after its strobe, and `data_out` is 0 whenever `data_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ack_pulse | input | 1 | One-cycle strobe per acknowledge pulse |
| init_start | input | 1 | Start of a new initialization; resets the pulse count |
| mode_8bit | input | 1 | 1 = three-pulse call mode, 0 = two-pulse pointer mode |
| intv4 | input | 1 | 1 = address interval 4, 0 = interval 8 |
| level | input | 3 | Resolved interrupt level 0..7 |
| vec_lo_bits | input | 3 | Programmed low-address bits 7:5 (bit 0 unused at interval 8) |
| vec_hi_byte | input | 8 | Programmed high address byte |
| ptr_base | input | 5 | Programmed pointer bits 7:3 |
| data_out | output | 8 | Byte returned for the pulse |
| data_oe | output | 1 | Drive enable for `data_out` |
| set_isr | output | 1 | Strobe: set the in-service bit of the sampled level |
| last_pulse | output | 1 | Strobe: this pulse ends the sequence |

## Verification
The three-pulse sequence runs at both intervals. Its address bits are chosen so that a level placed at the wrong bit offset, or an unused programmed bit that leaks into the byte, gives a different value. A level changed between pulses separates a level held from the in-service pulse from a live one. Pointer-mode runs at two levels and two bases show whether the first pulse stays silent and whether the in-service and end strobes land on the second pulse. Initialization alone, and initialization coinciding with a strobe, then show whether the count restarts and whether the coinciding strobe is dropped.

// File: rtl/iack_seq_pkg.sv
package iack_seq_pkg;
  localparam int BYTE_W   = 8;
  localparam int LVL_W    = 3;
  localparam int PBASE_W  = BYTE_W - LVL_W;
  localparam logic [BYTE_W-1:0] CALL_OPCODE = 8'hCD;

  typedef enum logic [1:0] {
    PULSE_FIRST  = 2'd0,
    PULSE_SECOND = 2'd1,
    PULSE_THIRD  = 2'd2
  } pulse_e;

  // low address byte of the call form; interval picks the level offset
  function automatic logic [BYTE_W-1:0] low_addr_byte(
    input logic             iv4,
    input logic [2:0]       prog,
    input logic [LVL_W-1:0] lvl
  );
    if (iv4) return {prog, lvl, 2'b00};
    else     return {prog[2:1], lvl, 3'b000};
  endfunction
endpackage

// File: rtl/iack_pulse_counter.sv
module iack_pulse_counter
  import iack_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   ack,
  input  logic   init,
  input  logic   mode8,
  output pulse_e idx,
  output logic   isr_now,
  output logic   last_now
);
  pulse_e idx_q;

  assign idx = idx_q;

  always_comb begin
    if (mode8) begin
      isr_now  = (idx_q == PULSE_FIRST);
      last_now = (idx_q == PULSE_THIRD);
    end else begin
      isr_now  = (idx_q != PULSE_FIRST);
      last_now = (idx_q != PULSE_FIRST);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      idx_q <= PULSE_FIRST;
    else if (init)   idx_q <= PULSE_FIRST;
    else if (ack) begin
      if (last_now)  idx_q <= PULSE_FIRST;
      else           idx_q <= pulse_e'(idx_q + 2'd1);
    end
  end
endmodule

// File: rtl/iack_byte_mux.sv
module iack_byte_mux
  import iack_seq_pkg::*;
(
  input  pulse_e              idx,
  input  logic                mode8,
  input  logic                iv4,
  input  logic [LVL_W-1:0]    lvl,
  input  logic [2:0]          lo_bits,
  input  logic [BYTE_W-1:0]   hi_byte,
  input  logic [PBASE_W-1:0]  pbase,
  output logic [BYTE_W-1:0]   byte_o,
  output logic                drive_o
);
  always_comb begin
    byte_o  = '0;
    drive_o = 1'b1;
    if (mode8) begin
      case (idx)
        PULSE_FIRST:  byte_o = CALL_OPCODE;
        PULSE_SECOND: byte_o = low_addr_byte(iv4, lo_bits, lvl);
        default:      byte_o = hi_byte;
      endcase
    end else if (idx == PULSE_FIRST) begin
      drive_o = 1'b0;
    end else begin
      byte_o = {pbase, lvl};
    end
  end
endmodule

// File: rtl/iack_vector_seq.sv
module iack_vector_seq
  import iack_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ack_pulse,
  input  logic              init_start,
  input  logic              mode_8bit,
  input  logic              intv4,
  input  logic [2:0]        level,
  input  logic [2:0]        vec_lo_bits,
  input  logic [7:0]        vec_hi_byte,
  input  logic [4:0]        ptr_base,
  output logic [7:0]        data_out,
  output logic              data_oe,
  output logic              set_isr,
  output logic              last_pulse
);
  pulse_e             idx;
  logic               isr_now, last_now, drive;
  logic [LVL_W-1:0]   lvl_q, lvl_use;
  logic [BYTE_W-1:0]  byte_c;
  logic               fire;

  assign fire = ack_pulse & ~init_start;

  iack_pulse_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .ack(ack_pulse), .init(init_start),
    .mode8(mode_8bit), .idx(idx), .isr_now(isr_now), .last_now(last_now)
  );

  // level is frozen on the in-service pulse and reused afterwards
  assign lvl_use = isr_now ? level : lvl_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              lvl_q <= '0;
    else if (fire && isr_now) lvl_q <= level;
  end

  iack_byte_mux u_mux (
    .idx(idx), .mode8(mode_8bit), .iv4(intv4), .lvl(lvl_use),
    .lo_bits(vec_lo_bits), .hi_byte(vec_hi_byte), .pbase(ptr_base),
    .byte_o(byte_c), .drive_o(drive)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_out   <= '0;
      data_oe    <= 1'b0;
      set_isr    <= 1'b0;
      last_pulse <= 1'b0;
    end else begin
      data_oe    <= fire & drive;
      data_out   <= (fire & drive) ? byte_c : '0;
      set_isr    <= fire & isr_now;
      last_pulse <= fire & last_now;
    end
  end
endmodule

// File: rtl/iack_vector_seq_chk.sv
module iack_vector_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ack_pulse,
  input logic       init_start,
  input logic       mode_8bit,
  input logic [7:0] data_out,
  input logic       data_oe,
  input logic       set_isr,
  input logic       last_pulse
);
  a_r10_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !data_oe |-> data_out == 8'h00);

  a_r9_needs_clean_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe || set_isr || last_pulse) |-> ($past(ack_pulse) && !$past(init_start)));

  a_r2_call_opcode: assert property (@(posedge clk) disable iff (!rst_n)
    (set_isr && $past(mode_8bit)) |-> (data_oe && data_out == 8'hCD && !last_pulse));

  a_r8_ptr_joint_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    (last_pulse && !$past(mode_8bit)) |-> (set_isr && data_oe));

  a_r5_last_drives: assert property (@(posedge clk) disable iff (!rst_n)
    last_pulse |-> data_oe);
endmodule

bind iack_vector_seq iack_vector_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ack_pulse(ack_pulse), .init_start(init_start),
  .mode_8bit(mode_8bit), .data_out(data_out), .data_oe(data_oe),
  .set_isr(set_isr), .last_pulse(last_pulse)
);

// File: tb/iack_vector_seq_tb_top.sv
module iack_vector_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ack_pulse = 1'b0, init_start = 1'b0, mode_8bit = 1'b1, intv4 = 1'b1;
  logic [2:0] level = '0, vec_lo_bits = '0;
  logic [7:0] vec_hi_byte = '0;
  logic [4:0] ptr_base = '0;
  logic [7:0] data_out;
  logic       data_oe, set_isr, last_pulse;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  iack_vector_seq dut_i (
    .clk(clk), .rst_n(rst_n), .ack_pulse(ack_pulse), .init_start(init_start),
    .mode_8bit(mode_8bit), .intv4(intv4), .level(level), .vec_lo_bits(vec_lo_bits),
    .vec_hi_byte(vec_hi_byte), .ptr_base(ptr_base), .data_out(data_out),
    .data_oe(data_oe), .set_isr(set_isr), .last_pulse(last_pulse)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one strobe; returns at the negedge where the registered result is visible
  task automatic strobe();
    @(negedge clk) ack_pulse = 1'b1;
    @(negedge clk) ack_pulse = 1'b0;
  endtask

  task automatic expect_out(input string tag, input logic [7:0] d, input logic oe,
                            input logic si, input logic lp);
    chk({tag, " data"}, data_out, d);
    chk({tag, " oe"}, data_oe, oe);
    chk({tag, " set_isr"}, set_isr, si);
    chk({tag, " last"}, last_pulse, lp);
  endtask

  task automatic resync();
    @(negedge clk) init_start = 1'b1;
    @(negedge clk) init_start = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    expect_out("R1 in reset", 8'h00, 0, 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    expect_out("R1 after reset", 8'h00, 0, 0, 0);
  endtask

  task automatic t_call(input logic iv, input logic [2:0] lo, input logic [2:0] lv,
                        input logic [7:0] hi, input logic [7:0] exp_lo, input string rtag);
    resync();
    mode_8bit = 1'b1; intv4 = iv; vec_lo_bits = lo; level = lv; vec_hi_byte = hi;
    strobe();
    expect_out("R2 call op", 8'hCD, 1, 1, 0);
    @(negedge clk);
    expect_out("R10 gap", 8'h00, 0, 0, 0);
    strobe();
    expect_out({rtag, " low byte"}, exp_lo, 1, 0, 0);
    strobe();
    expect_out("R5 high byte", hi, 1, 0, 1);
    strobe();
    expect_out("R5 wrap to call op", 8'hCD, 1, 1, 0);
  endtask

  task automatic t_level_hold();
    resync();
    mode_8bit = 1'b1; intv4 = 1'b1; vec_lo_bits = 3'b010; level = 3'd5;
    strobe();
    level = 3'd2;
    strobe();
    expect_out("R6 held level", 8'b010_101_00, 1, 0, 0);
  endtask

  task automatic t_ptr(input logic [4:0] pb, input logic [2:0] lv);
    resync();
    mode_8bit = 1'b0; ptr_base = pb; level = ~lv;
    strobe();
    expect_out("R7 silent first", 8'h00, 0, 0, 0);
    level = lv;
    strobe();
    expect_out("R8 pointer", {pb, lv}, 1, 1, 1);
    strobe();
    expect_out("R8 wrap silent", 8'h00, 0, 0, 0);
  endtask

  task automatic t_init();
    resync();
    mode_8bit = 1'b1;
    strobe();
    resync();
    strobe();
    expect_out("R9 restart op", 8'hCD, 1, 1, 0);
    @(negedge clk) begin ack_pulse = 1'b1; init_start = 1'b1; end
    @(negedge clk) begin ack_pulse = 1'b0; init_start = 1'b0; end
    expect_out("R9 strobe dropped", 8'h00, 0, 0, 0);
    strobe();
    expect_out("R9 first after init", 8'hCD, 1, 1, 0);
  endtask

  initial begin
    #(4 * 200000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_call(1'b1, 3'b101, 3'd7, 8'h3C, 8'b101_111_00, "R3");
    t_call(1'b1, 3'b010, 3'd1, 8'hA5, 8'b010_001_00, "R3");
    t_call(1'b0, 3'b101, 3'd6, 8'h81, 8'b10_110_000, "R4");
    t_call(1'b0, 3'b011, 3'd3, 8'h7E, 8'b01_011_000, "R4");
    t_level_hold();
    t_ptr(5'b10101, 3'd3);
    t_ptr(5'b01110, 3'd4);
    t_init();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule